// File: doc/BRIEF.md
# Chip-Select Gated Command Register

This block re-drives a memory address/command bus through one rank of flops clocked on the rising edge. The bus has 21 data bits whose capture can be gated by two active-low chip selects. It also carries two clock-enable bits, two termination-control bits and the two chip selects themselves. A static strap, `gate_en`, picks the gating mode. When `gate_en` is high, the data bits load only on edges where at least one chip select is low. When `gate_en` is low, the data bits load on every edge. The clock-enable, termination and chip-select bits are never gated.

An active-low reset clears every output at once, without waiting for a clock edge. Reset release runs through a small three-state release machine that acts as a two-flop synchronizer. In HELD the register is in reset. The first clock edge after `rst_n` rises takes it to ARMING. The second edge takes it to LIVE. Any low level on `rst_n` returns it to HELD from any state. Captures happen only on edges where the machine is already in LIVE, so the first capture after release is on the third rising edge.

The block also exports `chk_en`, a registered qualifier for a downstream parity checker. It is high in the cycle after an edge on which the data bits were captured.

Top module: `cs_gated_cmd_reg`

## Requirements
- R1: With `gate_en` high and both `cs_n` bits high at a live edge, `q_data` keeps its previous value.
- R2: With `gate_en` high and at least one `cs_n` bit low at a live edge, `q_data` takes the value of `d_data`.
- R3: With `gate_en` low, `q_data` takes `d_data` at every live edge, whatever the chip selects are.
- R4: `q_cke` and `q_odt` take `d_cke` and `d_odt` at every live edge, and chip select does not affect them.
- R5: `q_cs_n` takes `cs_n` at every live edge (bit 0 to bit 0, bit 1 to bit 1).
- R6: While `rst_n` is low, every output (`q_data`, `q_cs_n`, `q_cke`, `q_odt`, `chk_en`) is 0, and each output goes to 0 as soon as `rst_n` falls, without a clock edge. This reset overrides gating and `gate_en`.
- R7: After `rst_n` rises, the first two rising edges capture nothing and all outputs stay 0. The third edge is the first live edge.
- R8: After each live edge, `chk_en` is 1 if that edge captured the data bits (`gate_en` low, or any `cs_n` bit low) and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_en | input | 1 | 1 = data bits gated by chip select |
| cs_n | input | 2 | Active-low chip selects |
| d_data | input | 21 | Gated data bits |
| d_cke | input | 2 | Clock-enable bits |
| d_odt | input | 2 | Termination-control bits |
| q_data | output | 21 | Registered data bits |
| q_cs_n | output | 2 | Registered chip selects |
| q_cke | output | 2 | Registered clock-enable bits |
| q_odt | output | 2 | Registered termination bits |
| chk_en | output | 1 | Capture qualifier for a parity checker |

## Verification
The bench's corner cases are edges where both chip selects are high, with `gate_en` set and with it clear. A design that decodes the select with the wrong polarity, or with AND in place of OR, would load or hold on those edges when it should not. The bench asserts reset in the middle of a run, away from any clock edge, and checks the outputs at once. An implementation that clears only on a clock edge would show stale data at that check. The bench also counts the edges after release: a synchronizer that is one flop too short or too long would move the first capture by one cycle. It also checks that the clock-enable and termination bits follow their inputs during gated cycles, so that wrongly gating them shows up.

// File: rtl/cs_gated_cmd_reg_pkg.sv
package cs_gated_cmd_reg_pkg;
    localparam int unsigned DATA_BITS = 21;
    localparam int unsigned SEL_BITS  = 2;
    localparam int unsigned CKE_BITS  = 2;
    localparam int unsigned ODT_BITS  = 2;

    typedef enum logic [1:0] {
        REL_HELD   = 2'd0,
        REL_ARMING = 2'd1,
        REL_LIVE   = 2'd2
    } rel_state_e;
endpackage

// File: rtl/cmdreg_release_fsm.sv
module cmdreg_release_fsm
    import cs_gated_cmd_reg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic live
);
    rel_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REL_HELD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        live    = 1'b0;
        unique case (state_q)
            REL_HELD:   state_d = REL_ARMING;
            REL_ARMING: state_d = REL_LIVE;
            REL_LIVE: begin
                state_d = REL_LIVE;
                live    = 1'b1;
            end
            default:    state_d = REL_HELD;
        endcase
    end

    // R7
    arming_to_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == REL_ARMING) |=> (state_q == REL_LIVE));
    // R7
    held_to_arming_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == REL_HELD) |=> (state_q == REL_ARMING));
endmodule

// File: rtl/cmdreg_lane.sv
module cmdreg_lane #(
    parameter int unsigned WIDTH = 2,
    parameter bit          GATED = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             live,
    input  logic             sel_hit,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic take;

    generate
        if (GATED) begin : g_gated
            assign take = live & sel_hit;

            // R1
            hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (live && !sel_hit) |=> $stable(q));
            // R2
            load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (live && sel_hit) |=> (q == $past(d)));
        end else begin : g_free
            assign take = live;

            // R4
            follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                live |=> (q == $past(d)));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (take) q <= d;
    end

    // R7
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !live |=> (q == '0) || $stable(q));
endmodule

// File: rtl/cs_gated_cmd_reg.sv
module cs_gated_cmd_reg
    import cs_gated_cmd_reg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 gate_en,
    input  logic [SEL_BITS-1:0]  cs_n,
    input  logic [DATA_BITS-1:0] d_data,
    input  logic [CKE_BITS-1:0]  d_cke,
    input  logic [ODT_BITS-1:0]  d_odt,
    output logic [DATA_BITS-1:0] q_data,
    output logic [SEL_BITS-1:0]  q_cs_n,
    output logic [CKE_BITS-1:0]  q_cke,
    output logic [ODT_BITS-1:0]  q_odt,
    output logic                 chk_en
);
    logic live;
    logic sel_hit;

    assign sel_hit = !gate_en || !(&cs_n);

    cmdreg_release_fsm u_release (
        .clk   (clk),
        .rst_n (rst_n),
        .live  (live)
    );

    cmdreg_lane #(.WIDTH(DATA_BITS), .GATED(1'b1)) u_data (
        .clk(clk), .rst_n(rst_n), .live(live), .sel_hit(sel_hit),
        .d(d_data), .q(q_data));

    cmdreg_lane #(.WIDTH(SEL_BITS), .GATED(1'b0)) u_sel (
        .clk(clk), .rst_n(rst_n), .live(live), .sel_hit(sel_hit),
        .d(cs_n), .q(q_cs_n));

    cmdreg_lane #(.WIDTH(CKE_BITS), .GATED(1'b0)) u_cke (
        .clk(clk), .rst_n(rst_n), .live(live), .sel_hit(sel_hit),
        .d(d_cke), .q(q_cke));

    cmdreg_lane #(.WIDTH(ODT_BITS), .GATED(1'b0)) u_odt (
        .clk(clk), .rst_n(rst_n), .live(live), .sel_hit(sel_hit),
        .d(d_odt), .q(q_odt));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    chk_en <= 1'b0;
        else if (live) chk_en <= sel_hit;
        else           chk_en <= 1'b0;
    end

    // R6
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (q_data == '0 && q_cs_n == '0 && q_cke == '0
                    && q_odt == '0 && !chk_en));
    // R8
    qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && (!gate_en || cs_n != '1)) |=> chk_en);
    // R3
    ungated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !gate_en) |=> (q_data == $past(d_data)));
    // R5
    sel_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live |=> (q_cs_n == $past(cs_n)));
endmodule

// File: tb/cs_gated_cmd_reg_bench.sv
`timescale 1ns/100ps
module cs_gated_cmd_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        gate_en;
    logic [1:0]  cs_n;
    logic [20:0] d_data;
    logic [1:0]  d_cke, d_odt;
    logic [20:0] q_data;
    logic [1:0]  q_cs_n, q_cke, q_odt;
    logic        chk_en;

    int checks = 0;
    int errors = 0;
    int seed   = 32'h5eed;
    bit done   = 1'b0;

    logic [20:0] e_data;
    logic [1:0]  e_cs, e_cke, e_odt;
    logic        e_chk;
    int          rel;

    always #2.5 clk = ~clk;

    cs_gated_cmd_reg u_cs_gated_cmd_reg (
        .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .cs_n(cs_n),
        .d_data(d_data), .d_cke(d_cke), .d_odt(d_odt),
        .q_data(q_data), .q_cs_n(q_cs_n), .q_cke(q_cke), .q_odt(q_odt),
        .chk_en(chk_en));

    function automatic bit takes(input logic ge, input logic [1:0] cs);
        return !ge || (cs != 2'b11);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        e_data = '0; e_cs = '0; e_cke = '0; e_odt = '0; e_chk = 1'b0; rel = 0;
    endtask

    task automatic check_all(input string dreq);
        check(dreq, {11'd0, q_data}, {11'd0, e_data});
        check("R5", {30'd0, q_cs_n}, {30'd0, e_cs});
        check("R4", {28'd0, q_cke, q_odt}, {28'd0, e_cke, e_odt});
        check("R8", {31'd0, chk_en}, {31'd0, e_chk});
    endtask

    // one cycle: inputs already driven at a falling edge
    task automatic step();
        string dreq;
        @(posedge clk);
        #0.1;
        dreq = !gate_en ? "R3" : (cs_n == 2'b11 ? "R1" : "R2");
        if (!rst_n) begin
            model_clear();
            dreq = "R6";
        end else if (rel < 2) begin
            rel++;
            dreq = "R7";
        end else begin
            if (takes(gate_en, cs_n)) e_data = d_data;
            e_cs  = cs_n;
            e_cke = d_cke;
            e_odt = d_odt;
            e_chk = takes(gate_en, cs_n);
        end
        @(negedge clk);
        check_all(dreq);
    endtask

    task automatic drive_rand(input logic ge);
        gate_en = ge;
        cs_n    = 2'($urandom);
        d_data  = 21'($urandom);
        d_cke   = 2'($urandom);
        d_odt   = 2'($urandom);
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(seed));
        rst_n = 1'b0; gate_en = 1'b1; cs_n = 2'b11;
        d_data = '1; d_cke = '1; d_odt = '1;
        model_clear();
        repeat (2) @(negedge clk);
        // R6: outputs zero during reset despite active inputs
        check_all("R6");

        // R7: release, first two edges capture nothing
        rst_n = 1'b0; #1; rst_n = 1'b1;
        gate_en = 1'b0; cs_n = 2'b00;
        d_data = 21'h15A5A5; d_cke = 2'b11; d_odt = 2'b10;
        step(); step();
        check("R7", {11'd0, q_data}, 32'd0);
        step();
        check("R7", {11'd0, q_data}, {11'd0, 21'h15A5A5});

        // R1 directed: gated hold with both selects high
        gate_en = 1'b1; cs_n = 2'b11; d_data = 21'h0F0F0F; d_cke = 2'b01; d_odt = 2'b01;
        step();
        // R2 directed: only cs_n[1] low
        cs_n = 2'b01; d_data = 21'h1ABCDE;
        step();
        // R3 directed: both high but gating off
        gate_en = 1'b0; cs_n = 2'b11; d_data = 21'h012345;
        step();

        for (int i = 0; i < 300; i++) begin
            drive_rand(1'b1);
            if (i % 3 == 0) cs_n = 2'b11;
            step();
        end
        for (int i = 0; i < 300; i++) begin
            drive_rand(1'b0);
            step();
        end

        // R6: reset mid-cycle, away from clock edge
        drive_rand(1'b0);
        cs_n = 2'b00;
        step();
        #1;
        rst_n = 1'b0;
        #0.5;
        model_clear();
        check("R6", {11'd0, q_data}, 32'd0);
        check("R6", {25'd0, q_cs_n, q_cke, q_odt, chk_en}, 32'd0);
        @(negedge clk);
        drive_rand(1'b0);
        step();
        rst_n = 1'b1;
        for (int i = 0; i < 200; i++) begin
            drive_rand(1'($urandom));
            step();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule